// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Snooping

This block holds a small number of pending operations for one class of execution unit, such as an adder. Each operation arrives from the issue stage with its two source operands. An operand is either a finished value or the tag of the station that will produce it. Operands that are still waiting are filled in by watching a single result broadcast bus. When the tag on the bus matches an operand's producer tag, the slot takes the data and clears the tag. No register file is read.

Once both operands of a slot are present, the slot asks for dispatch. The lowest-numbered ready slot is offered to the execution unit and leaves when the unit accepts it. The slot stays occupied until its own destination tag appears on the broadcast bus. That frees it for a new issue. The issue stage sees a free-slot indication and must stall while the pool is full.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free, `iss_ready` is 1 and `disp_valid` is 0.
- R2: An issue is accepted on a clock edge where `iss_valid` and `iss_ready` are both 1, and it goes into the lowest-numbered free slot. `iss_ready` is 0 exactly when all `N_ENT` slots are occupied. An issue offered while `iss_ready` is 0 leaves no trace at the dispatch port.
- R3: A producer tag of 0 means the operand value given with it is valid. A nonzero tag means the operand waits, and a slot with any waiting operand never dispatches.
- R4: When `cdb_valid` is 1, every occupied, not yet dispatched slot with an operand tag equal to `cdb_tag` takes `cdb_data` into that operand and clears its tag. This covers several slots and both operands in the same cycle. The slot can dispatch from the next cycle on.
- R5: `disp_valid` is 1 whenever some occupied, not yet dispatched slot has both tags equal to 0. `disp_op`, `disp_a`, `disp_b` and `disp_dst` then carry that slot's contents.
- R6: Among the ready slots, the lowest-numbered one is offered. It leaves the dispatch port only on a clock edge where `fu_ready` is 1, and it is never offered again.
- R7: A dispatched slot becomes free on a clock edge where `cdb_valid` is 1 and `cdb_tag` equals the slot's destination tag. From the next cycle it can take a new issue.
- R8: If an issued operand's nonzero tag matches `cdb_tag` while `cdb_valid` is 1 in the issue cycle, the slot stores `cdb_data` with a cleared tag. The broadcast is not missed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Operation code carried to the unit |
| iss_a_tag | input | 4 | Producer tag of operand A, 0 when value valid |
| iss_a_val | input | 64 | Value of operand A |
| iss_b_tag | input | 4 | Producer tag of operand B, 0 when value valid |
| iss_b_val | input | 64 | Value of operand B |
| iss_dst | input | 4 | Tag this operation broadcasts its result under |
| iss_ready | output | 1 | A free slot exists; issue accepted this cycle |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the producing station |
| cdb_data | input | 64 | Broadcast result value |
| fu_ready | input | 1 | Execution unit accepts an operation this cycle |
| disp_valid | output | 1 | An operation is offered to the unit |
| disp_op | output | 4 | Offered operation code |
| disp_a | output | 64 | Offered operand A |
| disp_b | output | 64 | Offered operand B |
| disp_dst | output | 4 | Offered destination tag |

## Verification
A slot that misses a broadcast shows up as a `disp_valid` that never rises for that operation. A slot that captures the wrong data shows up as a wrong `disp_a` or `disp_b` in the cycle it is offered. A slot whose occupancy is wrong shows up at `iss_ready` one cycle after the faulty edge, or as an extra operation at the dispatch port. Every cycle, the bench compares `iss_ready` and the whole dispatch port against a behavioural model. Any of these faults therefore surfaces within a cycle of reaching a port. This includes long random runs with dependent tags, random broadcast timing and random unit back-pressure.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int RS_DATA_W = 64;
    parameter int RS_TAG_W  = 4;
    parameter int RS_OP_W   = 4;

    typedef logic [RS_DATA_W-1:0] data_t;
    typedef logic [RS_TAG_W-1:0]  tag_t;
    typedef logic [RS_OP_W-1:0]   op_t;

    // operand as held in a slot: waiting tag (0 = present) and value
    typedef struct packed {
        tag_t  q;
        data_t v;
    } opnd_t;

    // one result broadcast
    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } bcast_t;

    // take the broadcast value if the operand is waiting on it
    function automatic opnd_t snoop(opnd_t o, bcast_t b);
        opnd_t r;
        r = o;
        if (b.valid && (o.q != '0) && (o.q == b.tag)) begin
            r.q = '0;
            r.v = b.data;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
    assign any = |req;
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc_i,
    input  op_t    op_i,
    input  opnd_t  a_i,
    input  opnd_t  b_i,
    input  tag_t   dst_i,
    input  bcast_t bc_i,
    input  logic   grant_i,
    output logic   busy_o,
    output logic   req_o,
    output op_t    op_o,
    output data_t  a_o,
    output data_t  b_o,
    output tag_t   dst_o
);
    logic  busy_q, sent_q;
    op_t   op_q;
    tag_t  dst_q;
    opnd_t a_q, b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            op_q   <= '0;
            dst_q  <= '0;
            a_q    <= '0;
            b_q    <= '0;
        end else if (alloc_i) begin
            busy_q <= 1'b1;
            sent_q <= 1'b0;
            op_q   <= op_i;
            dst_q  <= dst_i;
            a_q    <= snoop(a_i, bc_i);
            b_q    <= snoop(b_i, bc_i);
        end else if (busy_q) begin
            if (!sent_q) begin
                a_q <= snoop(a_q, bc_i);
                b_q <= snoop(b_q, bc_i);
                if (grant_i) sent_q <= 1'b1;
            end else if (bc_i.valid && bc_i.tag == dst_q) begin
                busy_q <= 1'b0;
                sent_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
    assign req_o  = busy_q && !sent_q && (a_q.q == '0) && (b_q.q == '0);
    assign op_o   = op_q;
    assign a_o    = a_q.v;
    assign b_o    = b_q.v;
    assign dst_o  = dst_q;

    assert_alloc_free_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_i |-> !busy_q);

    assert_grant_ready_R5: assert property (@(posedge clk) disable iff (rst)
        grant_i |-> (a_q.q == '0 && b_q.q == '0 && busy_q && !sent_q));

    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !sent_q && !alloc_i && bc_i.valid && a_q.q != '0 && a_q.q == bc_i.tag)
        |=> (a_q.q == '0 && a_q.v == $past(bc_i.data)));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (alloc_i && bc_i.valid && b_i.q != '0 && b_i.q == bc_i.tag)
        |=> (b_q.q == '0 && b_q.v == $past(bc_i.data)));

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && sent_q && bc_i.valid && bc_i.tag == dst_q) |=> !busy_q);
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [RS_OP_W-1:0]   iss_op,
    input  logic [RS_TAG_W-1:0]  iss_a_tag,
    input  logic [RS_DATA_W-1:0] iss_a_val,
    input  logic [RS_TAG_W-1:0]  iss_b_tag,
    input  logic [RS_DATA_W-1:0] iss_b_val,
    input  logic [RS_TAG_W-1:0]  iss_dst,
    output logic                 iss_ready,
    input  logic                 cdb_valid,
    input  logic [RS_TAG_W-1:0]  cdb_tag,
    input  logic [RS_DATA_W-1:0] cdb_data,
    input  logic                 fu_ready,
    output logic                 disp_valid,
    output logic [RS_OP_W-1:0]   disp_op,
    output logic [RS_DATA_W-1:0] disp_a,
    output logic [RS_DATA_W-1:0] disp_b,
    output logic [RS_TAG_W-1:0]  disp_dst
);
    bcast_t bc;
    opnd_t  a_in, b_in;
    assign bc   = '{valid: cdb_valid, tag: cdb_tag, data: cdb_data};
    assign a_in = '{q: iss_a_tag, v: iss_a_val};
    assign b_in = '{q: iss_b_tag, v: iss_b_val};

    logic [N_ENT-1:0] busy_v, req_v, alloc_gnt, disp_gnt;
    op_t   op_v  [N_ENT];
    data_t a_v   [N_ENT];
    data_t b_v   [N_ENT];
    tag_t  dst_v [N_ENT];
    logic  any_free, any_ready;

    rs_pick #(.N(N_ENT)) u_alloc (.req(~busy_v), .gnt(alloc_gnt), .any(any_free));
    rs_pick #(.N(N_ENT)) u_disp  (.req(req_v),   .gnt(disp_gnt),  .any(any_ready));

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        rs_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .alloc_i (iss_valid && alloc_gnt[g]),
            .op_i    (iss_op),
            .a_i     (a_in),
            .b_i     (b_in),
            .dst_i   (iss_dst),
            .bc_i    (bc),
            .grant_i (fu_ready && disp_gnt[g]),
            .busy_o  (busy_v[g]),
            .req_o   (req_v[g]),
            .op_o    (op_v[g]),
            .a_o     (a_v[g]),
            .b_o     (b_v[g]),
            .dst_o   (dst_v[g])
        );
    end

    always_comb begin
        disp_op  = '0;
        disp_a   = '0;
        disp_b   = '0;
        disp_dst = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (disp_gnt[i]) begin
                disp_op  = disp_op  | op_v[i];
                disp_a   = disp_a   | a_v[i];
                disp_b   = disp_b   | b_v[i];
                disp_dst = disp_dst | dst_v[i];
            end
        end
    end

    assign iss_ready  = any_free;
    assign disp_valid = any_ready;

    assert_one_dispatch_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(disp_gnt) && (disp_valid == (disp_gnt != '0)));

    assert_full_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (!iss_ready && !(cdb_valid)) |=> !iss_ready);
endmodule

// File: tb/sim_rs_pool.sv
module sim_rs_pool;
    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 0;
    logic [3:0]  iss_op = 0, iss_a_tag = 0, iss_b_tag = 0, iss_dst = 0;
    logic [63:0] iss_a_val = 0, iss_b_val = 0;
    logic        iss_ready;
    logic        cdb_valid = 0;
    logic [3:0]  cdb_tag = 0;
    logic [63:0] cdb_data = 0;
    logic        fu_ready = 0;
    logic        disp_valid;
    logic [3:0]  disp_op, disp_dst;
    logic [63:0] disp_a, disp_b;

    always #(CLK_P/2) clk = ~clk;

    rs_pool #(.N_ENT(N)) u0 (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;

    // behavioural model of the pool
    bit          m_busy[N], m_sent[N];
    int          m_qa[N], m_qb[N], m_op[N], m_dst[N];
    logic [63:0] m_va[N], m_vb[N];

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int free_slot();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    function automatic int ready_slot();
        for (int i = 0; i < N; i++)
            if (m_busy[i] && !m_sent[i] && m_qa[i] == 0 && m_qb[i] == 0) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_sent[i] = 0;
        end
    endtask

    // compare ports with model, then advance model and clock
    task automatic step();
        int f, d;
        #1;
        f = free_slot();
        d = ready_slot();
        check("R2 iss_ready", iss_ready, f >= 0);
        check("R5 disp_valid", disp_valid, d >= 0);
        if (d >= 0 && disp_valid) begin
            check("R6 disp_dst", disp_dst, m_dst[d]);
            check("R6 disp_op", disp_op, m_op[d]);
            check("R4 disp_a", disp_a, m_va[d]);
            check("R4 disp_b", disp_b, m_vb[d]);
        end
        for (int i = 0; i < N; i++) begin
            if (!m_busy[i]) continue;
            if (!m_sent[i]) begin
                if (cdb_valid && m_qa[i] != 0 && m_qa[i] == cdb_tag) begin m_qa[i] = 0; m_va[i] = cdb_data; end
                if (cdb_valid && m_qb[i] != 0 && m_qb[i] == cdb_tag) begin m_qb[i] = 0; m_vb[i] = cdb_data; end
            end else if (cdb_valid && m_dst[i] == cdb_tag) begin
                m_busy[i] = 0; m_sent[i] = 0;
            end
        end
        if (d >= 0 && fu_ready) m_sent[d] = 1;
        if (iss_valid && f >= 0) begin
            m_busy[f] = 1; m_sent[f] = 0;
            m_op[f] = iss_op; m_dst[f] = iss_dst;
            m_qa[f] = iss_a_tag; m_va[f] = iss_a_val;
            m_qb[f] = iss_b_tag; m_vb[f] = iss_b_val;
            if (cdb_valid && iss_a_tag != 0 && iss_a_tag == cdb_tag) begin m_qa[f] = 0; m_va[f] = cdb_data; end
            if (cdb_valid && iss_b_tag != 0 && iss_b_tag == cdb_tag) begin m_qb[f] = 0; m_vb[f] = cdb_data; end
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle();
        iss_valid = 0; cdb_valid = 0; fu_ready = 0;
    endtask

    task automatic issue(int op, int at, logic [63:0] av, int bt, logic [63:0] bv, int dst);
        iss_valid = 1; iss_op = op[3:0];
        iss_a_tag = at[3:0]; iss_a_val = av;
        iss_b_tag = bt[3:0]; iss_b_val = bv;
        iss_dst = dst[3:0];
    endtask

    task automatic bcast(int tag, logic [63:0] data);
        cdb_valid = 1; cdb_tag = tag[3:0]; cdb_data = data;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1 iss_ready after reset", iss_ready, 1);
        check("R1 disp_valid after reset", disp_valid, 0);

        // ready operands, unit stalled
        issue(1, 0, 64'd10, 0, 64'd20, 1); step(); idle();
        check("R3 ready slot offered", disp_valid, 1);
        check("R5 operand a", disp_a, 64'd10);
        check("R5 operand b", disp_b, 64'd20);
        issue(2, 5, 64'd0, 0, 64'd30, 2); step(); idle();
        check("R6 lowest held while stalled", disp_dst, 1);
        fu_ready = 1; step(); idle();
        check("R3 waiting tag not offered", disp_valid, 0);
        bcast(5, 64'd77); step(); idle();
        check("R4 captured broadcast", disp_a, 64'd77);
        check("R4 woken slot offered", disp_dst, 2);
        fu_ready = 1; step(); idle();
        bcast(1, 64'hAA); step(); idle();
        issue(3, 0, 64'd5, 0, 64'd6, 3); step(); idle();
        check("R7 freed slot reused", disp_dst, 3);
        fu_ready = 1; bcast(2, 64'h1); step(); idle();
        bcast(3, 64'h2); step(); idle();
        check("R7 all free again", iss_ready, 1);

        // fill pool with waiting operations
        for (int k = 0; k < N; k++) begin
            issue(4, 9, 64'd0, 0, 64'(k), 10 + k); step(); idle();
        end
        check("R2 full pool", iss_ready, 0);
        issue(5, 0, 64'd1, 0, 64'd2, 14); step(); idle();
        check("R2 issue while full ignored", disp_valid, 0);
        bcast(9, 64'h99); step(); idle();
        check("R4 multi wake", disp_a, 64'h99);
        check("R6 lowest of many", disp_dst, 10);
        for (int k = 0; k < N; k++) begin fu_ready = 1; step(); idle(); end
        check("R2 no ghost op", disp_valid, 0);
        for (int k = 0; k < N; k++) begin bcast(10 + k, 64'h0); step(); idle(); end
        check("R7 drained", iss_ready, 1);

        // same-cycle bypass
        issue(6, 7, 64'hDEAD, 7, 64'hBEEF, 15); bcast(7, 64'h1234); step(); idle();
        check("R8 bypass valid", disp_valid, 1);
        check("R8 bypass a", disp_a, 64'h1234);
        check("R8 bypass b", disp_b, 64'h1234);
        fu_ready = 1; step(); idle();
        bcast(15, 64'h0); step(); idle();

        // random dependent traffic
        for (int k = 0; k < 3000; k++) begin
            iss_valid = $urandom_range(0, 1);
            iss_op    = 4'($urandom);
            iss_a_tag = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            iss_b_tag = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            iss_a_val = {$urandom, $urandom};
            iss_b_val = {$urandom, $urandom};
            iss_dst   = 4'($urandom_range(1, 15));
            cdb_valid = $urandom_range(0, 1);
            cdb_tag   = 4'($urandom_range(1, 15));
            cdb_data  = {$urandom, $urandom};
            fu_ready  = ($urandom_range(0, 9) < 6);
            step();
        end
        idle();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule